// File: doc/BRIEF.md
# Sleep Type Control Decoder

This block holds a 3-bit sleep-type control field that software writes over a simple register strobe, and turns it into the platform's sleep control outputs. The block keeps the written code exactly as given, so a read always returns it. A small state machine takes the decoded power state and drives four outputs: processor clock-stop, processor sleep, suspend-to-RAM and deep-off request. Codes that have no defined meaning are kept in the field, but the state machine treats them as the fully-on state.

The same write word carries a global-release command bit. Writing it as 1 sends a one-cycle SMI request pulse toward firmware. The bit is never stored and always reads back as 0.

The state machine has five states. ON drives all outputs low. STOP_GRANT drives clock-stop. CPU_SLEEP drives clock-stop and processor sleep. SUSPEND_RAM drives suspend. DEEP_OFF drives the deep-off request. Reset enters ON. Every write moves the machine to the state its code selects: 000 goes to ON, 001 to STOP_GRANT, 010 to CPU_SLEEP, 011 to SUSPEND_RAM, 100 to DEEP_OFF, and 101, 110 and 111 go to ON. Any state can move to any other state in this way. Without a write the machine stays where it is.

Top module: `sleep_ctrl_top`

## Requirements
- R1: During reset and after it, until the first write, all four sleep outputs and smi_o are 0.
- R2: After a write of code 000 in wr_data[2:0], all four sleep outputs are 0.
- R3: After a write of code 001, only stpclk_o is 1.
- R4: After a write of code 010, stpclk_o and cpu_sleep_o are 1, and suspend_o and deep_off_o are 0.
- R5: After a write of code 011, only suspend_o is 1.
- R6: After a write of code 100, only deep_off_o is 1.
- R7: After a write of code 101, 110 or 111, all four sleep outputs are 0, which is the on state.
- R8: While rd_en is 1, rd_data[2:0] returns the last code written, including the reserved codes 101 to 111, and rd_data[3] reads 0. While rd_en is 0, rd_data is 0.
- R9: A write with wr_data[3] = 1 makes smi_o 1 for exactly the one cycle after the write strobe. Back-to-back writes give one pulse per write.
- R10: The sleep outputs change only on the clock edge that samples wr_en = 1, and they become visible one cycle after the strobe. They hold while wr_en is 0.
- R11: A write with wr_data[3] = 0 produces no SMI pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 4 | [2:0] sleep code, [3] global-release command |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 4 | Read word: stored code in [2:0], 0 in [3] |
| stpclk_o | output | 1 | Processor clock-stop request |
| cpu_sleep_o | output | 1 | Processor sleep request |
| suspend_o | output | 1 | Suspend-to-RAM indication |
| deep_off_o | output | 1 | Deep-off (disk suspend or soft-off) request |
| smi_o | output | 1 | One-cycle SMI request to firmware |

## Verification
The assertions check on every cycle that the sleep outputs hold when there is no write and that a reserved code leaves them all low. They also check that processor sleep never appears without clock-stop, that every SMI pulse traces back to a write with the release bit set, and that the field captures the written code. Only the bench scenarios show the exact output pattern for each defined code, the one-cycle latency, the readback of reserved codes with the release bit reading zero, and the outputs staying in the on state before the first write. The bench covers these by comparing against its behavioural model on every clock.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

    typedef enum logic [2:0] {
        PS_ON          = 3'd0,
        PS_STOP_GRANT  = 3'd1,
        PS_CPU_SLEEP   = 3'd2,
        PS_SUSPEND_RAM = 3'd3,
        PS_DEEP_OFF    = 3'd4
    } pwr_state_e;

    typedef struct packed {
        logic stpclk;
        logic cpu_sleep;
        logic suspend;
        logic deep_off;
    } sleep_outs_t;

    // Map a written code to its power state; any undefined code maps to on.
    function automatic pwr_state_e code_to_state(input logic [2:0] code);
        pwr_state_e st;
        unique case (code)
            3'd1:    st = PS_STOP_GRANT;
            3'd2:    st = PS_CPU_SLEEP;
            3'd3:    st = PS_SUSPEND_RAM;
            3'd4:    st = PS_DEEP_OFF;
            default: st = PS_ON;
        endcase
        return st;
    endfunction

endpackage

// File: rtl/sleep_type_field.sv
module sleep_type_field #(
    parameter int TYPE_W = 3,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TYPE_W-1:0] wr_code,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PAD_W = DATA_W - TYPE_W;

    // No reset: the field holds whatever was written last, reserved codes included.
    logic [TYPE_W-1:0] field_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            field_q <= wr_code;
        end
    end

    always_comb begin
        if (rd_en) begin
            rd_data = {{PAD_W{1'b0}}, field_q};
        end else begin
            rd_data = '0;
        end
    end

    AST_FIELD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (field_q == $past(wr_code))); // R8

    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && $past(rst_n) |=> $stable(field_q)); // R8

endmodule

// File: rtl/sleep_state_fsm.sv
module sleep_state_fsm
    import sleep_ctrl_pkg::*;
#(
    parameter int TYPE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TYPE_W-1:0] wr_code,
    output sleep_outs_t       outs
);

    pwr_state_e state_q;
    pwr_state_e state_d;

    // Next-state logic: each write jumps straight to the state its code selects.
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d = code_to_state(3'(wr_code));
        end
    end

    // State register: reset forces the on state until the first write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_ON;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode: a pure function of the registered state.
    always_comb begin
        outs = '0;
        unique case (state_q)
            PS_ON:          outs = '0;
            PS_STOP_GRANT:  outs.stpclk = 1'b1;
            PS_CPU_SLEEP:   begin
                outs.stpclk    = 1'b1;
                outs.cpu_sleep = 1'b1;
            end
            PS_SUSPEND_RAM: outs.suspend  = 1'b1;
            PS_DEEP_OFF:    outs.deep_off = 1'b1;
            default:        outs = '0;
        endcase
    end

    AST_RESERVED_ON: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_code > TYPE_W'(4)) |=> (outs == '0)); // R7

    AST_SLEEP_NEEDS_STPCLK: assert property (@(posedge clk) disable iff (!rst_n)
        outs.cpu_sleep |-> outs.stpclk); // R4

    AST_OUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && $past(rst_n) |=> $stable(outs)); // R10

    AST_ONE_DEEP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({outs.stpclk, outs.suspend, outs.deep_off})); // R6

endmodule

// File: rtl/gbl_release_pulse.sv
module gbl_release_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic rel_bit,
    output logic smi_o
);

    // Command bit is not stored; each write of 1 yields a single registered pulse.
    logic smi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_q <= 1'b0;
        end else begin
            smi_q <= wr_en & rel_bit;
        end
    end

    assign smi_o = smi_q;

    AST_SMI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_o) |-> $past(wr_en && rel_bit)); // R9

    AST_NO_SMI_WITHOUT_REL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !rel_bit |=> !smi_o); // R11

endmodule

// File: rtl/sleep_ctrl_top.sv
module sleep_ctrl_top
    import sleep_ctrl_pkg::*;
#(
    parameter int TYPE_W  = 3,
    parameter int REL_BIT = 3,
    parameter int DATA_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              stpclk_o,
    output logic              cpu_sleep_o,
    output logic              suspend_o,
    output logic              deep_off_o,
    output logic              smi_o
);

    logic [TYPE_W-1:0] code;
    sleep_outs_t       outs;

    assign code = wr_data[TYPE_W-1:0];

    sleep_type_field #(
        .TYPE_W (TYPE_W),
        .DATA_W (DATA_W)
    ) u_field (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_code (code),
        .rd_en   (rd_en),
        .rd_data (rd_data)
    );

    sleep_state_fsm #(
        .TYPE_W (TYPE_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_code (code),
        .outs    (outs)
    );

    gbl_release_pulse u_rel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rel_bit (wr_data[REL_BIT]),
        .smi_o   (smi_o)
    );

    assign stpclk_o    = outs.stpclk;
    assign cpu_sleep_o = outs.cpu_sleep;
    assign suspend_o   = outs.suspend;
    assign deep_off_o  = outs.deep_off;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !smi_o && !stpclk_o && !suspend_o && !deep_off_o); // R1

endmodule

// File: tb/sleep_ctrl_top_tb.sv
module sleep_ctrl_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [3:0] rd_data;
    logic       stpclk_o, cpu_sleep_o, suspend_o, deep_off_o, smi_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural reference state
    int  m_code = -1;      // -1: nothing written since reset
    int  m_stored = -1;    // last code written (survives reset)
    bit  m_smi = 1'b0;

    always #10 clk = ~clk;

    sleep_ctrl_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .stpclk_o(stpclk_o),
        .cpu_sleep_o(cpu_sleep_o), .suspend_o(suspend_o),
        .deep_off_o(deep_off_o), .smi_o(smi_o)
    );

    always @(posedge clk) begin
        if (wr_en) m_stored <= int'(wr_data[2:0]);
        if (!rst_n) begin
            m_code <= -1;
            m_smi  <= 1'b0;
        end else begin
            if (wr_en) m_code <= int'(wr_data[2:0]);
            m_smi <= wr_en && wr_data[3];
        end
    end

    function automatic logic [3:0] exp_outs(input int c);
        case (c)
            1: return 4'b1000;
            2: return 4'b1100;
            3: return 4'b0010;
            4: return 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic string out_tag(input int c);
        case (c)
            -1: return "R1";
            0: return "R2/R10";
            1: return "R3/R10";
            2: return "R4/R10";
            3: return "R5/R10";
            4: return "R6/R10";
            default: return "R7/R10";
        endcase
    endfunction

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        logic [3:0] got, exp;
        if (!done) begin
            got = {stpclk_o, cpu_sleep_o, suspend_o, deep_off_o};
            exp = exp_outs(m_code);
            checks++;
            if (got !== exp) begin
                fails++;
                $display("FAIL %s outs actual=%b expected=%b", out_tag(m_code), got, exp);
            end
            checks++;
            if (smi_o !== m_smi) begin
                fails++;
                $display("FAIL %s smi actual=%b expected=%b",
                         m_smi ? "R9" : (rst_n ? "R11" : "R1"), smi_o, m_smi);
            end
            if (rd_en && m_stored >= 0) begin
                checks++;
                if (rd_data !== {1'b0, 3'(m_stored)}) begin
                    fails++;
                    $display("FAIL R8 rd_data actual=%b expected=%b", rd_data, {1'b0, 3'(m_stored)});
                end
            end else if (!rd_en) begin
                checks++;
                if (rd_data !== 4'b0) begin
                    fails++;
                    $display("FAIL R8 rd_data idle actual=%b expected=0000", rd_data);
                end
            end
        end
    end

    task automatic step(input bit we, input logic [3:0] d, input bit re);
        @(negedge clk);
        #2;
        wr_en = we;
        wr_data = d;
        rd_en = re;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) step(0, 4'h0, 0);
        step(0, 4'h0, 0);
        rst_n = 1'b1;
        repeat (3) step(0, 4'h0, 0);            // R1: on until first write
        // Each defined and reserved code, then idle cycles (R2..R7, R10), with readback (R8)
        for (int c = 0; c < 8; c++) begin
            step(1, 4'(c), 0);
            step(0, 4'h0, 1);
            step(0, 4'h0, 1);
            step(0, 4'h0, 0);
        end
        // Transitions straight between sleep states
        step(1, 4'h4, 0); step(1, 4'h1, 0); step(1, 4'h3, 0); step(1, 4'h2, 0);
        step(1, 4'h6, 1); step(0, 4'h0, 1);
        // Global release: R9 pulses, R11 none, back-to-back
        step(1, 4'hB, 0); step(0, 4'h0, 1); step(0, 4'h0, 0);
        step(1, 4'h9, 0); step(1, 4'h9, 0); step(1, 4'h1, 0);
        step(0, 4'h0, 1); step(0, 4'h0, 0);
        // Reset in deep state returns to on (R1)
        step(1, 4'h4, 0); step(0, 4'h0, 0);
        rst_n = 1'b0;
        step(0, 4'h0, 0); step(0, 4'h0, 0);
        rst_n = 1'b1;
        step(0, 4'h0, 0); step(0, 4'h0, 0);
        step(1, 4'h7, 0); step(0, 4'h0, 1); step(0, 4'h0, 0);
        @(negedge clk);
        #1;
        finish_run();
    end

endmodule